// File: doc/BRIEF.md
# Accumulator round-and-saturate unit

This block turns wide accumulator contents into register-width results. The caller pulses a request with a mode, a signed 3-bit shift count, a source-accumulator index and the current value of flag F0. One cycle later the block presents either a rounded and clamped 32-bit result as a high/low word pair, or a clamped 16-bit high word. It also presents the updated flag pair. The accumulators come in as ports. The surrounding core writes the results into its register file.

Pair mode joins accumulator 0 and the low word of accumulator 1 into one wide signed value. It shifts that value, adds half of the lowest kept bit, drops the low word and clamps to the signed 32-bit range. High-word mode sign-extends accumulator 1, shifts it and clamps it to 32 bits without rounding, then keeps the upper 16 bits. Pair mode only accepts accumulator 0 as its source. Any other index raises a fault pulse instead of a result.

The controller has three states. ST_IDLE means nothing is pending. ST_RESULT means a legal request completed last cycle. ST_FAULT means an illegal request arrived last cycle. From every state the transitions are the same. A legal request goes to ST_RESULT, an illegal request goes to ST_FAULT, and no request goes to ST_IDLE.

Top module: `arsu_store`

## Requirements
- R1: After reset, valid_o and fault_o are low, word_hi_o and word_lo_o are zero, and f0_o and f1_o are zero.
- R2: A legal request in cycle n gives valid_o high in cycle n+1 only. A request in every cycle gives a result in every cycle.
- R3: shift_i is signed two's complement, with 3'b100 = -4 up to 3'b011 = +3. A positive count shifts left and a negative count shifts right arithmetically.
- R4: Pair mode is selected by mode_i = 0. The value is acc0 sign-extended, followed by acc1[15:0] as its lower 16 bits. After the shift, 0x8000 is added and the value is shifted right by 16. word_hi_o holds result bits 31:16 and word_lo_o holds bits 15:0.
- R5: In pair mode, a result above 0x7FFFFFFF gives word_hi_o = 0x7FFF and word_lo_o = 0xFFFF. A result below -0x80000000 gives 0x8000 and 0x0000.
- R6: High-word mode is selected by mode_i = 1. acc1 is sign-extended and shifted without rounding. word_hi_o holds bits 31:16 and word_lo_o is 0.
- R7: In high-word mode, a shifted value outside the signed 32-bit range gives word_hi_o = 0x7FFF if positive or 0x8000 if negative.
- R8: With each result, f1_o takes the f0_i value sampled with the request. f0_o is 1 when clamping occurred and 0 otherwise.
- R9: A pair-mode request with src_sel_i other than 0 gives fault_o high for one cycle and valid_o low. The words and flags keep their previous values. High-word mode ignores src_sel_i.
- R10: With no request, valid_o and fault_o are low in the next cycle and the words and flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe |
| mode_i | input | 1 | 0 = pair result, 1 = high-word result |
| src_sel_i | input | 1 | Source accumulator index |
| shift_i | input | 3 | Signed shift count |
| acc0_i | input | 40 | Accumulator 0 |
| acc1_i | input | 40 | Accumulator 1 |
| f0_i | input | 1 | Current F0 flag |
| valid_o | output | 1 | Result presented this cycle |
| fault_o | output | 1 | Illegal request reported this cycle |
| word_hi_o | output | 16 | Upper result word |
| word_lo_o | output | 16 | Lower result word |
| f0_o | output | 1 | New F0: clamping occurred |
| f1_o | output | 1 | New F1: previous F0 |

## Verification
Pair mode is driven with values that fall exactly on the rounding tie, both positive and negative. These show whether the half-LSB add comes before the truncating shift and whether the truncation is arithmetic. Both extreme shift counts are applied, which separates the signed decoding of the count from an unsigned reading. Values just inside and just past the 32-bit limits in each mode expose clamp thresholds that are off by one and mix-ups between the positive and negative limit. Wide random operands of scattered magnitude, mixed with illegal source indices and idle cycles, are checked every clock against a behavioural model using 64-bit integers.

// File: rtl/arsu_pkg.sv
package arsu_pkg;
    typedef enum logic {
        MODE_PAIR = 1'b0,
        MODE_HIGH = 1'b1
    } arsu_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } arsu_state_e;
endpackage

// File: rtl/arsu_shift.sv
// Signed barrel shift: negative count shifts right arithmetically.
module arsu_shift #(
    parameter int W    = 60,
    parameter int SH_W = 3
) (
    input  logic signed [W-1:0]    d,
    input  logic        [SH_W-1:0] amt,
    output logic signed [W-1:0]    q
);
    logic [SH_W-1:0] mag;

    always_comb begin
        mag = amt[SH_W-1] ? (~amt + SH_W'(1)) : amt;
        if (amt[SH_W-1]) q = d >>> mag;
        else             q = d <<< mag;
    end
endmodule

// File: rtl/arsu_clamp.sv
// Clamp a signed value to OUT_W signed bits by checking the discarded top bits.
module arsu_clamp #(
    parameter int IN_W  = 60,
    parameter int OUT_W = 32
) (
    input  logic signed [IN_W-1:0] v,
    output logic        [OUT_W-1:0] q,
    output logic                    sat
);
    logic over, under;

    always_comb begin
        over  = ~v[IN_W-1] &  (|v[IN_W-2:OUT_W-1]);
        under =  v[IN_W-1] & ~(&v[IN_W-2:OUT_W-1]);
        sat   = over | under;
        if (over)       q = {1'b0, {(OUT_W-1){1'b1}}};
        else if (under) q = {1'b1, {(OUT_W-1){1'b0}}};
        else            q = v[OUT_W-1:0];
    end
endmodule

// File: rtl/arsu_store.sv
module arsu_store #(
    parameter int ACC_W    = 40,
    parameter int WORD_W   = 16,
    parameter int SHIFT_W  = 3,
    parameter int NUM_ACC  = 2,
    parameter int PAIR_SRC = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_i,
    input  logic                        mode_i,
    input  logic [$clog2(NUM_ACC)-1:0]  src_sel_i,
    input  logic [SHIFT_W-1:0]          shift_i,
    input  logic [ACC_W-1:0]            acc0_i,
    input  logic [ACC_W-1:0]            acc1_i,
    input  logic                        f0_i,
    output logic                        valid_o,
    output logic                        fault_o,
    output logic [WORD_W-1:0]           word_hi_o,
    output logic [WORD_W-1:0]           word_lo_o,
    output logic                        f0_o,
    output logic                        f1_o
);
    import arsu_pkg::*;

    localparam int HEADROOM = 2 ** (SHIFT_W - 1);
    localparam int PAIR_W   = ACC_W + WORD_W + HEADROOM;
    localparam int HIGH_W   = ACC_W + HEADROOM;
    localparam int RES_W    = 2 * WORD_W;
    localparam int SEL_W    = $clog2(NUM_ACC);
    localparam logic [PAIR_W-1:0] ROUND_HALF = PAIR_W'(1) << (WORD_W - 1);

    // Pair datapath: join, shift, round, clamp
    logic signed [PAIR_W-1:0] pair_raw, pair_shifted, pair_sum, pair_round;
    logic        [RES_W-1:0]  pair_q;
    logic                     pair_sat;

    assign pair_raw = $signed({{HEADROOM{acc0_i[ACC_W-1]}}, acc0_i, acc1_i[WORD_W-1:0]});

    arsu_shift #(.W(PAIR_W), .SH_W(SHIFT_W)) i_pair_shift (
        .d   (pair_raw),
        .amt (shift_i),
        .q   (pair_shifted)
    );

    assign pair_sum   = pair_shifted + $signed(ROUND_HALF);
    assign pair_round = pair_sum >>> WORD_W;

    arsu_clamp #(.IN_W(PAIR_W), .OUT_W(RES_W)) i_pair_clamp (
        .v   (pair_round),
        .q   (pair_q),
        .sat (pair_sat)
    );

    // High-word datapath: extend, shift, clamp
    logic signed [HIGH_W-1:0] high_raw, high_shifted;
    logic        [RES_W-1:0]  high_q;
    logic                     high_sat;

    assign high_raw = $signed({{HEADROOM{acc1_i[ACC_W-1]}}, acc1_i});

    arsu_shift #(.W(HIGH_W), .SH_W(SHIFT_W)) i_high_shift (
        .d   (high_raw),
        .amt (shift_i),
        .q   (high_shifted)
    );

    arsu_clamp #(.IN_W(HIGH_W), .OUT_W(RES_W)) i_high_clamp (
        .v   (high_shifted),
        .q   (high_q),
        .sat (high_sat)
    );

    // Request decode
    logic             req_legal;
    logic [RES_W-1:0] sel_res;
    logic             sel_sat;

    always_comb begin
        req_legal = !((mode_i == MODE_PAIR) && (src_sel_i != SEL_W'(PAIR_SRC)));
        if (mode_i == MODE_PAIR) begin
            sel_res = pair_q;
            sel_sat = pair_sat;
        end else begin
            sel_res = {high_q[RES_W-1:WORD_W], {WORD_W{1'b0}}};
            sel_sat = high_sat;
        end
    end

    // Controller
    arsu_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_FAULT: begin
                if (!req_i)         state_d = ST_IDLE;
                else if (req_legal) state_d = ST_RESULT;
                else                state_d = ST_FAULT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_hi_o <= '0;
            word_lo_o <= '0;
            f0_o      <= 1'b0;
            f1_o      <= 1'b0;
        end else if (req_i && req_legal) begin
            word_hi_o <= sel_res[RES_W-1:WORD_W];
            word_lo_o <= sel_res[WORD_W-1:0];
            f0_o      <= sel_sat;
            f1_o      <= f0_i;
        end
    end

    always_comb begin
        valid_o = (state_q == ST_RESULT);
        fault_o = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/arsu_checker.sv
module arsu_checker #(
    parameter int WORD_W  = 16,
    parameter int SEL_W   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              mode_i,
    input logic [SEL_W-1:0]  src_sel_i,
    input logic              f0_i,
    input logic              valid_o,
    input logic              fault_o,
    input logic [WORD_W-1:0] word_hi_o,
    input logic [WORD_W-1:0] word_lo_o,
    input logic              f0_o,
    input logic              f1_o
);
    logic bad_src;
    assign bad_src = (mode_i == 1'b0) && (src_sel_i != '0);

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !bad_src) |=> (valid_o && !fault_o)); // R2

    AST_FAULT_ON_BAD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && bad_src) |=> (fault_o && !valid_o && $stable(word_hi_o) && $stable(f0_o))); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!valid_o && !fault_o && $stable(word_hi_o) && $stable(word_lo_o))); // R10

    AST_FLAG_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !bad_src) |=> (f1_o == $past(f0_i))); // R8

    AST_CLAMP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && f0_o) |-> (word_hi_o == {1'b0, {(WORD_W-1){1'b1}}} ||
                               word_hi_o == {1'b1, {(WORD_W-1){1'b0}}})); // R5

    AST_HIGH_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i) |=> (valid_o && word_lo_o == '0)); // R6

    AST_NO_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && fault_o)); // R9
endmodule

bind arsu_store arsu_checker #(.WORD_W(WORD_W), .SEL_W(SEL_W)) i_arsu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .mode_i    (mode_i),
    .src_sel_i (src_sel_i),
    .f0_i      (f0_i),
    .valid_o   (valid_o),
    .fault_o   (fault_o),
    .word_hi_o (word_hi_o),
    .word_lo_o (word_lo_o),
    .f0_o      (f0_o),
    .f1_o      (f1_o)
);

// File: tb/test_arsu_store.sv
module test_arsu_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [0:0]  src_sel_i = '0;
    logic [2:0]  shift_i = '0;
    logic [39:0] acc0_i = '0;
    logic [39:0] acc1_i = '0;
    logic        f0_i = 1'b0;
    logic        valid_o, fault_o, f0_o, f1_o;
    logic [15:0] word_hi_o, word_lo_o;

    always #10 clk = ~clk;

    arsu_store i_arsu_store (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .src_sel_i(src_sel_i), .shift_i(shift_i), .acc0_i(acc0_i),
        .acc1_i(acc1_i), .f0_i(f0_i), .valid_o(valid_o), .fault_o(fault_o),
        .word_hi_o(word_hi_o), .word_lo_o(word_lo_o), .f0_o(f0_o), .f1_o(f1_o)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    string exp_tag  = "R1";
    logic        e_valid = 0, e_fault = 0, e_f0 = 0, e_f1 = 0;
    logic [15:0] e_hi = 0, e_lo = 0;

    function automatic longint sext40(logic [39:0] v);
        return longint'({{24{v[39]}}, v});
    endfunction

    function automatic longint do_shift(longint v, logic [2:0] s);
        int amt = int'($signed(s));
        if (amt >= 0) return v <<< amt;
        return v >>> (-amt);
    endfunction

    task automatic compare();
        n_checks++;
        if (valid_o !== e_valid || fault_o !== e_fault || word_hi_o !== e_hi ||
            word_lo_o !== e_lo || f0_o !== e_f0 || f1_o !== e_f1) begin
            n_fail++;
            $display("FAIL %s: actual v=%b f=%b hi=%h lo=%h f0=%b f1=%b expected v=%b f=%b hi=%h lo=%h f0=%b f1=%b",
                     exp_tag, valid_o, fault_o, word_hi_o, word_lo_o, f0_o, f1_o,
                     e_valid, e_fault, e_hi, e_lo, e_f0, e_f1);
        end
    endtask

    task automatic step(input bit req, input bit mode, input bit src,
                        input logic [2:0] sh, input logic [39:0] a0,
                        input logic [39:0] a1, input bit f0, input string tag);
        longint t;
        bit     sat;
        @(negedge clk);
        compare();
        req_i = req; mode_i = mode; src_sel_i = src; shift_i = sh;
        acc0_i = a0; acc1_i = a1; f0_i = f0;
        exp_tag = tag;
        e_valid = 0; e_fault = 0;
        if (req && !mode && src) begin
            e_fault = 1;
        end else if (req) begin
            e_valid = 1;
            if (!mode) t = (do_shift((sext40(a0) <<< 16) | longint'(a1[15:0]), sh) + 32768) >>> 16;
            else       t = do_shift(sext40(a1), sh);
            sat = 0;
            if (t > 64'sd2147483647)       begin t = 64'sd2147483647;  sat = 1; end
            else if (t < -64'sd2147483648) begin t = -64'sd2147483648; sat = 1; end
            e_hi = t[31:16];
            e_lo = mode ? 16'h0 : t[15:0];
            e_f0 = sat;
            e_f1 = f0;
        end
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 3'd0, 40'd0, 40'd0, 0, tag);
    endtask

    function automatic logic [39:0] rnd_acc();
        longint r = longint'({$urandom, $urandom});
        r = r >>> ($urandom % 40);
        return r[39:0];
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1");                                             // reset state checked here
        step(1, 0, 0, 3'd0, 40'h12, 40'h0_3456_ABCD, 0, "R4");   // plain pair
        step(1, 0, 0, 3'd0, 40'h0, 40'h8000, 0, "R4");           // positive tie rounds up
        step(1, 0, 0, 3'd0, 40'hFF_FFFF_FFFF, 40'h8000, 0, "R4");// negative tie
        step(1, 0, 0, 3'd0, 40'hFF_FFFF_FFFF, 40'h7FFF, 0, "R4");
        step(1, 0, 0, 3'b011, 40'h0_0123_4567, 40'h89AB, 0, "R3"); // +3
        step(1, 0, 0, 3'b100, 40'h0_0123_4567, 40'h89AB, 0, "R3"); // -4
        step(1, 0, 0, 3'b111, 40'hFF_F123_4567, 40'h0001, 0, "R3"); // -1 arithmetic
        step(1, 0, 0, 3'd0, 40'h00_7FFF_FFFF, 40'h8000, 0, "R5");   // round pushes past max
        step(1, 0, 0, 3'd0, 40'h00_7FFF_FFFF, 40'h7FFF, 0, "R5");   // just inside
        step(1, 0, 0, 3'd0, 40'hFF_8000_0000, 40'h0000, 0, "R5");   // exactly min
        step(1, 0, 0, 3'd1, 40'hFF_8000_0000, 40'h0000, 0, "R5");   // below min
        step(1, 1, 0, 3'd0, 40'h0, 40'h00_1234_5678, 0, "R6");
        step(1, 1, 1, 3'b110, 40'h0, 40'hFF_8765_4321, 0, "R6");    // src ignored, -2
        step(1, 1, 0, 3'd1, 40'h0, 40'h00_4000_0000, 0, "R7");      // to 0x8000_0000 -> clamp
        step(1, 1, 0, 3'd0, 40'h0, 40'h00_7FFF_FFFF, 0, "R7");
        step(1, 1, 0, 3'd3, 40'h0, 40'hFF_F000_0000, 0, "R7");      // exactly min
        step(1, 1, 0, 3'd3, 40'h0, 40'hFF_EFFF_FFFF, 0, "R7");      // below min
        step(1, 0, 0, 3'd0, 40'h5, 40'h5, 1, "R8");
        step(1, 0, 0, 3'd3, 40'h7F_0000_0000, 40'h0, 1, "R8");
        step(1, 0, 1, 3'd0, 40'h1, 40'h1, 0, "R9");                 // illegal source
        step(1, 0, 1, 3'd2, 40'h7F_0000_0000, 40'h0, 1, "R9");
        step(1, 0, 0, 3'd0, 40'h1, 40'h2, 0, "R2");
        step(1, 1, 0, 3'd0, 40'h1, 40'h0_0002_0000, 1, "R2");
        idle("R10");
        idle("R10");
        for (int i = 0; i < 600; i++) begin
            bit rq = ($urandom % 6) != 0;
            bit md = $urandom % 2;
            bit sr = ($urandom % 5) == 0;
            step(rq, md, sr, 3'($urandom), rnd_acc(), rnd_acc(), 1'($urandom),
                 !rq ? "R10" : (!md && sr) ? "R9" : md ? "R7" : "R5");
        end
        idle("R10");
        @(negedge clk);
        compare();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule